// File: doc/BRIEF.md
# Debug Bus-Abandon Request Controller

This block sits on the path between a processor's bus interface and the system bus. It gives an external debugger a way to break a bus deadlock so that the core can reach its halted debug state. The debugger writes a one-cycle control word that holds a cancel bit and a halt bit. Authentication inputs decide whether that write is allowed to take effect. Once the cancel flag is set, every transaction the core is still waiting on is answered locally, in issue order, with zero data and an OK response. The slave is not waited for, and no error is ever returned.

Downstream requests pass through a single register stage, and responses come back in order. A per-entry abandoned marker in the outstanding-transaction tracker causes late downstream answers for transactions that were already abandoned to be dropped. A store still waiting in the request register when the cancel flag rises has its write data forced to zero. New core requests are refused while the cancel flag is set or while the core reports that it is halted. Both flags clear when the core acknowledges entry into debug state.

Top module: `dbg_bus_abandon`

## Requirements
- R1: Reset is synchronous and active low. Afterwards `halt_req`, `cancel_active`, `up_rsp_valid` and `dn_req_valid` are 0, and `up_req_ready` is 1 provided that `core_halted` is 0.
- R2: With `SEC_EXT`=1, a control write (`cfg_we`=1) changes neither flag unless `dbg_en` and `sec_dbg_en` are both 1.
- R3: With `SEC_EXT`=0, a control write changes neither flag unless `dbg_en` is 1. `sec_dbg_en` is ignored in this mode.
- R4: A permitted write with `cfg_halt`=1 sets `halt_req` on the next cycle. A permitted write with `cfg_cancel`=1 sets `cancel_active` on the next cycle, but only if `cfg_halt` is 1 in the same write or `halt_req` is already 1. If both bits are written together, both flags set in the same cycle.
- R5: `halt_ack`=1 clears both flags on the next cycle, and it wins over a control write made in the same cycle.
- R6: An accepted core request appears on the `dn_req_*` port in the cycle after acceptance and is held until `dn_req_ready`. A downstream response for a transaction that has not been abandoned is passed to `up_rsp_*` in the same cycle, with its data and error bit unchanged.
- R7: While `cancel_active` is 1, outstanding transactions that have not been answered receive a local response (`up_rsp_valid`=1, data 0, `up_rsp_err`=0). The first comes in the first cycle that `cancel_active` is 1, and then one follows per cycle, oldest first. `up_rsp_valid` falls once all have been answered.
- R8: A downstream response for a transaction that was already abandoned is discarded and does not raise `up_rsp_valid`.
- R9: A store (kind code 1; load is 0, fetch is 2) held in the downstream request register while the cancel flag is set shows `dn_req_wdata`=0 until it is taken, even after the flag clears.
- R10: `up_req_ready` is 0 while `cancel_active` or `core_halted` is 1.
- R11: With `DEPTH` transactions outstanding, `up_req_ready` is 0.
- R12: If a downstream response for the oldest unanswered transaction arrives in a cycle when a local abandon would answer that same transaction, the real response is forwarded, and local answering continues with the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_cancel | input | 1 | Cancel bit of the control word |
| cfg_halt | input | 1 | Halt bit of the control word |
| dbg_en | input | 1 | Invasive debug enable |
| sec_dbg_en | input | 1 | Secure privileged debug enable |
| halt_req | output | 1 | Pending halt request to the core |
| halt_ack | input | 1 | Core acknowledges debug-state entry |
| core_halted | input | 1 | Core is in debug state |
| cancel_active | output | 1 | Cancel flag |
| up_req_valid | input | 1 | Core request valid |
| up_req_ready | output | 1 | Core request accepted |
| up_req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| up_req_addr | input | AW | Request address |
| up_req_wdata | input | DW | Store data |
| up_rsp_valid | output | 1 | Response to core |
| up_rsp_rdata | output | DW | Response data |
| up_rsp_err | output | 1 | Response error |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request taken |
| dn_req_kind | output | 2 | Downstream access kind |
| dn_req_addr | output | AW | Downstream address |
| dn_req_wdata | output | DW | Downstream store data |
| dn_rsp_valid | input | 1 | Downstream response valid (in order) |
| dn_rsp_rdata | input | DW | Downstream response data |
| dn_rsp_err | input | 1 | Downstream response error |

## Verification
A real downstream response for the oldest unanswered transaction can arrive in the same cycle that the cancel flag would answer that transaction locally. The bench provokes this by raising `dn_rsp_valid` with a distinctive data word in the first cycle that `cancel_active` is high. It then expects that word on `up_rsp_rdata`, followed one cycle later by a zero-data local answer for the next transaction. A second overlap is also driven: a late response for an abandoned entry arrives while a younger entry is being abandoned. Here the bench expects only the zero-data local answer to reach the core.

// File: rtl/dbg_abn_pkg.sv
package dbg_abn_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/dbg_abn_auth.sv
module dbg_abn_auth #(
    parameter bit SEC_EXT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_cancel,
    input  logic cfg_halt,
    input  logic dbg_en,
    input  logic sec_dbg_en,
    input  logic halt_ack,
    output logic cancel_o,
    output logic halt_o
);
    typedef struct packed {
        logic cancel;
        logic halt;
    } flag_t;

    flag_t st_d, st_q;
    logic  permit;

    // The gating mode is chosen at build time.
    generate
        if (SEC_EXT) begin : g_sec
            assign permit = dbg_en & sec_dbg_en;
        end else begin : g_nosec
            assign permit = dbg_en;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (cfg_we && permit) begin
            if (cfg_halt) st_d.halt = 1'b1;
            // Cancel may only stand alongside a pending halt.
            if (cfg_cancel && (cfg_halt || st_q.halt)) st_d.cancel = 1'b1;
        end
        if (halt_ack) begin
            st_d.cancel = 1'b0;
            st_d.halt   = 1'b0;
        end
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign cancel_o = st_q.cancel;
    assign halt_o   = st_q.halt;

    p_cancel_with_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cancel |-> st_q.halt);
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        halt_ack |=> (!st_q.cancel && !st_q.halt));
    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.cancel) |-> $past(cfg_we && cfg_cancel && dbg_en && (!SEC_EXT || sec_dbg_en)));
endmodule

// File: rtl/dbg_abn_req_stage.sv
module dbg_abn_req_stage
    import dbg_abn_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [1:0]    kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          cancel,
    input  logic          dn_ready,
    output logic          dn_valid,
    output logic [1:0]    dn_kind,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_wdata,
    output logic          space
);
    typedef struct packed {
        logic          valid;
        logic          zero;
        acc_kind_e     kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.valid = 1'b1;
            st_d.zero  = 1'b0;
            st_d.kind  = acc_kind_e'(kind_i);
            st_d.addr  = addr_i;
            st_d.wdata = wdata_i;
        end else if (st_q.valid && dn_ready) begin
            st_d.valid = 1'b0;
            st_d.zero  = 1'b0;
        end else if (st_q.valid && cancel) begin
            st_d.zero  = 1'b1;
        end
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign dn_valid = st_q.valid;
    assign dn_kind  = st_q.kind;
    assign dn_addr  = st_q.addr;
    assign dn_wdata = ((cancel || st_q.zero) && st_q.kind == ACC_STORE) ? '0 : st_q.wdata;
    assign space    = !st_q.valid || dn_ready;

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr)));
    p_load_when_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> space);
endmodule

// File: rtl/dbg_abn_tracker.sv
module dbg_abn_tracker #(
    parameter int DEPTH = 4,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          cancel,
    input  logic          dn_rsp_valid,
    input  logic [DW-1:0] dn_rsp_rdata,
    input  logic          dn_rsp_err,
    output logic          full,
    output logic          up_rsp_valid,
    output logic [DW-1:0] up_rsp_rdata,
    output logic          up_rsp_err
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    typedef struct packed {
        logic [PW-1:0]    head;
        logic [PW-1:0]    rsp;
        logic [PW-1:0]    tail;
        logic [DEPTH-1:0] abn;
    } trk_t;

    trk_t st_d, st_q;

    logic [PW-1:0] count;
    logic          head_abn;
    logic          fwd, local_done, unanswered;

    assign count      = st_q.tail - st_q.head;
    assign full       = (count == PW'(DEPTH));
    assign head_abn   = st_q.abn[st_q.head[IW-1:0]];
    assign unanswered = (st_q.rsp != st_q.tail);
    assign fwd        = dn_rsp_valid && !head_abn;
    assign local_done = cancel && !fwd && unanswered;

    always_comb begin
        st_d = st_q;
        if (dn_rsp_valid) begin
            st_d.abn[st_q.head[IW-1:0]] = 1'b0;
            st_d.head = st_q.head + 1'b1;
        end
        if (local_done) st_d.abn[st_q.rsp[IW-1:0]] = 1'b1;
        if (fwd || local_done) st_d.rsp = st_q.rsp + 1'b1;
        if (push) begin
            st_d.abn[st_q.tail[IW-1:0]] = 1'b0;
            st_d.tail = st_q.tail + 1'b1;
        end
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign up_rsp_valid = fwd || local_done;
    assign up_rsp_rdata = fwd ? dn_rsp_rdata : '0;
    assign up_rsp_err   = fwd ? dn_rsp_err : 1'b0;

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PW'(DEPTH));
    p_no_push_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    p_rsp_has_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_rsp_valid |-> (count != '0));
    p_fwd_is_oldest_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |-> (st_q.head == st_q.rsp));
endmodule

// File: rtl/dbg_bus_abandon.sv
module dbg_bus_abandon #(
    parameter bit SEC_EXT = 1'b1,
    parameter int DEPTH   = 4,
    parameter int AW      = 32,
    parameter int DW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_cancel,
    input  logic          cfg_halt,
    input  logic          dbg_en,
    input  logic          sec_dbg_en,
    output logic          halt_req,
    input  logic          halt_ack,
    input  logic          core_halted,
    output logic          cancel_active,
    input  logic          up_req_valid,
    output logic          up_req_ready,
    input  logic [1:0]    up_req_kind,
    input  logic [AW-1:0] up_req_addr,
    input  logic [DW-1:0] up_req_wdata,
    output logic          up_rsp_valid,
    output logic [DW-1:0] up_rsp_rdata,
    output logic          up_rsp_err,
    output logic          dn_req_valid,
    input  logic          dn_req_ready,
    output logic [1:0]    dn_req_kind,
    output logic [AW-1:0] dn_req_addr,
    output logic [DW-1:0] dn_req_wdata,
    input  logic          dn_rsp_valid,
    input  logic [DW-1:0] dn_rsp_rdata,
    input  logic          dn_rsp_err
);
    logic cancel_q, full, space, fire;

    dbg_abn_auth #(.SEC_EXT(SEC_EXT)) u_auth (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cancel(cfg_cancel),
        .cfg_halt(cfg_halt), .dbg_en(dbg_en), .sec_dbg_en(sec_dbg_en),
        .halt_ack(halt_ack), .cancel_o(cancel_q), .halt_o(halt_req)
    );

    assign cancel_active = cancel_q;
    assign up_req_ready  = !full && space && !cancel_q && !core_halted;
    assign fire          = up_req_valid && up_req_ready;

    dbg_abn_req_stage #(.AW(AW), .DW(DW)) u_stage (
        .clk(clk), .rst_n(rst_n), .load(fire), .kind_i(up_req_kind),
        .addr_i(up_req_addr), .wdata_i(up_req_wdata), .cancel(cancel_q),
        .dn_ready(dn_req_ready), .dn_valid(dn_req_valid), .dn_kind(dn_req_kind),
        .dn_addr(dn_req_addr), .dn_wdata(dn_req_wdata), .space(space)
    );

    dbg_abn_tracker #(.DEPTH(DEPTH), .DW(DW)) u_trk (
        .clk(clk), .rst_n(rst_n), .push(fire), .cancel(cancel_q),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata),
        .dn_rsp_err(dn_rsp_err), .full(full), .up_rsp_valid(up_rsp_valid),
        .up_rsp_rdata(up_rsp_rdata), .up_rsp_err(up_rsp_err)
    );

    p_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_active || core_halted) |-> !up_req_ready);
    p_local_needs_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && !dn_rsp_valid) |-> cancel_active);
    p_local_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && !dn_rsp_valid) |-> (up_rsp_rdata == '0 && !up_rsp_err));
endmodule

// File: tb/dbg_bus_abandon_tb_top.sv
`timescale 1ns/100ps
module dbg_bus_abandon_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cfg_we, cfg_cancel, cfg_halt, dbg_en, sec_dbg_en, halt_ack, core_halted;
    logic up_req_valid, dn_req_ready, dn_rsp_valid, dn_rsp_err;
    logic [1:0] up_req_kind;
    logic [AW-1:0] up_req_addr;
    logic [DW-1:0] up_req_wdata, dn_rsp_rdata;

    logic halt_req, cancel_active, up_req_ready, up_rsp_valid, up_rsp_err, dn_req_valid;
    logic [DW-1:0] up_rsp_rdata, dn_req_wdata;
    logic [1:0] dn_req_kind;
    logic [AW-1:0] dn_req_addr;

    logic ns_halt, ns_cancel, ns_ready, ns_rv, ns_rerr, ns_dv;
    logic [DW-1:0] ns_rdata, ns_wdata;
    logic [1:0] ns_kind;
    logic [AW-1:0] ns_addr;

    dbg_bus_abandon #(.SEC_EXT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cancel(cfg_cancel), .cfg_halt(cfg_halt),
        .dbg_en(dbg_en), .sec_dbg_en(sec_dbg_en), .halt_req(halt_req), .halt_ack(halt_ack),
        .core_halted(core_halted), .cancel_active(cancel_active), .up_req_valid(up_req_valid),
        .up_req_ready(up_req_ready), .up_req_kind(up_req_kind), .up_req_addr(up_req_addr),
        .up_req_wdata(up_req_wdata), .up_rsp_valid(up_rsp_valid), .up_rsp_rdata(up_rsp_rdata),
        .up_rsp_err(up_rsp_err), .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
        .dn_req_kind(dn_req_kind), .dn_req_addr(dn_req_addr), .dn_req_wdata(dn_req_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata), .dn_rsp_err(dn_rsp_err)
    );

    dbg_bus_abandon #(.SEC_EXT(1'b0)) dut_ns_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cancel(cfg_cancel), .cfg_halt(cfg_halt),
        .dbg_en(dbg_en), .sec_dbg_en(sec_dbg_en), .halt_req(ns_halt), .halt_ack(halt_ack),
        .core_halted(1'b0), .cancel_active(ns_cancel), .up_req_valid(1'b0),
        .up_req_ready(ns_ready), .up_req_kind(2'd0), .up_req_addr('0),
        .up_req_wdata('0), .up_rsp_valid(ns_rv), .up_rsp_rdata(ns_rdata),
        .up_rsp_err(ns_rerr), .dn_req_valid(ns_dv), .dn_req_ready(1'b0),
        .dn_req_kind(ns_kind), .dn_req_addr(ns_addr), .dn_req_wdata(ns_wdata),
        .dn_rsp_valid(1'b0), .dn_rsp_rdata('0), .dn_rsp_err(1'b0)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_flags();
        halt_ack = 1'b1;
        tick();
        halt_ack = 1'b0;
    endtask

    // {dbg_en, sec_dbg_en, cancel, halt, exp_cancel_sec, exp_halt_sec, exp_cancel_ns, exp_halt_ns}
    localparam logic [7:0] GATE_TBL [7] = '{
        8'b1111_1111,
        8'b1011_0011,
        8'b0111_0000,
        8'b0011_0000,
        8'b1110_0000,
        8'b1101_0101,
        8'b1001_0001
    };

    initial begin
        rst_n = 1'b0; cfg_we = 0; cfg_cancel = 0; cfg_halt = 0; dbg_en = 0; sec_dbg_en = 0;
        halt_ack = 0; core_halted = 0; up_req_valid = 0; up_req_kind = 0; up_req_addr = 0;
        up_req_wdata = 0; dn_req_ready = 0; dn_rsp_valid = 0; dn_rsp_rdata = 0; dn_rsp_err = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        #0.1;
        chk("R1 halt_req", 32'(halt_req), 0);
        chk("R1 cancel_active", 32'(cancel_active), 0);
        chk("R1 up_rsp_valid", 32'(up_rsp_valid), 0);
        chk("R1 dn_req_valid", 32'(dn_req_valid), 0);
        chk("R1 up_req_ready", 32'(up_req_ready), 1);

        // Gating table: R2 for the secure-mode instance, R3 for the other, R4 for flag pairing
        for (int i = 0; i < 7; i++) begin
            clear_flags();
            dbg_en = GATE_TBL[i][7]; sec_dbg_en = GATE_TBL[i][6];
            cfg_cancel = GATE_TBL[i][5]; cfg_halt = GATE_TBL[i][4]; cfg_we = 1'b1;
            tick();
            cfg_we = 1'b0;
            chk($sformatf("R2 R4 row%0d cancel", i), 32'(cancel_active), 32'(GATE_TBL[i][3]));
            chk($sformatf("R2 R4 row%0d halt", i), 32'(halt_req), 32'(GATE_TBL[i][2]));
            chk($sformatf("R3 row%0d cancel", i), 32'(ns_cancel), 32'(GATE_TBL[i][1]));
            chk($sformatf("R3 row%0d halt", i), 32'(ns_halt), 32'(GATE_TBL[i][0]));
        end
        clear_flags();

        // R5: acknowledge wins over a simultaneous write
        dbg_en = 1; sec_dbg_en = 1; cfg_we = 1; cfg_cancel = 1; cfg_halt = 1; halt_ack = 1;
        tick();
        cfg_we = 0; halt_ack = 0;
        chk("R5 ack beats write cancel", 32'(cancel_active), 0);
        chk("R5 ack beats write halt", 32'(halt_req), 0);

        // R4: cancel alone after a halt already pending
        cfg_we = 1; cfg_cancel = 0; cfg_halt = 1; tick();
        cfg_cancel = 1; cfg_halt = 0; tick();
        cfg_we = 0; cfg_cancel = 0;
        chk("R4 cancel after pending halt", 32'(cancel_active), 1);
        chk("R10 ready low under cancel", 32'(up_req_ready), 0);
        clear_flags();
        chk("R5 ack clears cancel", 32'(cancel_active), 0);
        chk("R5 ack clears halt", 32'(halt_req), 0);

        // R6: normal pass-through
        up_req_valid = 1; up_req_kind = 2'd0; up_req_addr = 32'h100; dn_req_ready = 0;
        #0.1;
        chk("R6 ready idle", 32'(up_req_ready), 1);
        tick();
        up_req_valid = 0;
        chk("R6 dn valid", 32'(dn_req_valid), 1);
        chk("R6 dn addr", dn_req_addr, 32'h100);
        dn_req_ready = 1; tick(); dn_req_ready = 0;
        chk("R6 dn taken", 32'(dn_req_valid), 0);
        dn_rsp_valid = 1; dn_rsp_rdata = 32'hAB; dn_rsp_err = 1;
        #0.1;
        chk("R6 fwd valid", 32'(up_rsp_valid), 1);
        chk("R6 fwd data", up_rsp_rdata, 32'hAB);
        chk("R6 fwd err", 32'(up_rsp_err), 1);
        tick();
        dn_rsp_valid = 0; dn_rsp_err = 0;
        #0.1;
        chk("R6 rsp done", 32'(up_rsp_valid), 0);

        // Four outstanding: load A, store B, fetch C issued; store D left in the stage
        dn_req_ready = 1;
        up_req_valid = 1; up_req_kind = 2'd0; up_req_addr = 32'h200; tick();
        up_req_kind = 2'd1; up_req_addr = 32'h204; up_req_wdata = 32'hDEAD; tick();
        up_req_kind = 2'd2; up_req_addr = 32'h208; tick();
        up_req_valid = 0; tick();
        dn_req_ready = 0;
        up_req_valid = 1; up_req_kind = 2'd1; up_req_addr = 32'h20C; up_req_wdata = 32'hBEEF; tick();
        up_req_valid = 0;
        chk("R6 store data", dn_req_wdata, 32'hBEEF);
        dn_req_ready = 1; #1;
        chk("R11 full blocks", 32'(up_req_ready), 0);
        dn_req_ready = 0; #1;

        // Cancel with halt
        @(posedge clk); #1;
        cfg_we = 1; cfg_cancel = 1; cfg_halt = 1; tick();
        cfg_we = 0; cfg_cancel = 0; cfg_halt = 0;
        chk("R4 both set cancel", 32'(cancel_active), 1);
        chk("R4 both set halt", 32'(halt_req), 1);
        chk("R7 first local valid", 32'(up_rsp_valid), 1);
        chk("R7 first local data", up_rsp_rdata, 0);
        dn_rsp_valid = 1; dn_rsp_rdata = 32'h55; #0.5;
        chk("R12 real rsp wins valid", 32'(up_rsp_valid), 1);
        chk("R12 real rsp wins data", up_rsp_rdata, 32'h55);
        tick();
        dn_rsp_valid = 0; #0.1;
        chk("R9 store zeroed", dn_req_wdata, 0);
        chk("R10 ready under cancel", 32'(up_req_ready), 0);
        chk("R12 next local valid", 32'(up_rsp_valid), 1);
        chk("R7 local B data", up_rsp_rdata, 0);
        tick();
        dn_rsp_valid = 1; dn_rsp_rdata = 32'h77; dn_rsp_err = 1; #0.1;
        chk("R8 late rsp dropped valid", 32'(up_rsp_valid), 1);
        chk("R8 late rsp dropped data", up_rsp_rdata, 0);
        chk("R8 late rsp dropped err", 32'(up_rsp_err), 0);
        tick();
        dn_rsp_valid = 0; dn_rsp_err = 0; #0.1;
        chk("R7 local D valid", 32'(up_rsp_valid), 1);
        tick();
        chk("R7 all answered", 32'(up_rsp_valid), 0);

        core_halted = 1; halt_ack = 1; tick(); halt_ack = 0;
        chk("R5 ack clears cancel", 32'(cancel_active), 0);
        chk("R5 ack clears halt", 32'(halt_req), 0);
        chk("R9 zero kept after clear", dn_req_wdata, 0);
        dn_req_ready = 1; #1;
        chk("R10 halted blocks", 32'(up_req_ready), 0);
        tick();
        dn_req_ready = 0;
        dn_rsp_valid = 1; dn_rsp_rdata = 32'h99; #0.1;
        chk("R8 drop C", 32'(up_rsp_valid), 0);
        tick();
        chk("R8 drop D", 32'(up_rsp_valid), 0);
        tick();
        dn_rsp_valid = 0; core_halted = 0; #0.1;
        chk("R10 ready restored", 32'(up_req_ready), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule